// File: doc/BRIEF.md
# Warm Reset Handshake Sequencer

This block orders a hardware warm reset. Any warm-reset cause input starts a sequence. Before any reset line goes active, the block can run up to five pre-reset handshakes with neighbouring subsystems, one at a time. A handshake can ask the memory controller to enter self-refresh. It can tell a configuration manager or a scan manager to park its output clock. It can notify the fabric logic. It can ask a trace bus master to finish its open transactions and start no new ones.

Once the handshakes are done, both reset outputs assert together for a fixed hold time. The clock-manager reset is then freed first. The remaining system resets follow after a programmable delay. An external reset pin can be pulsed for a programmable number of cycles, starting when the resets assert.

A sticky status word records three things: which causes were seen, which debug-reset requests arrived, and which handshakes timed out. Software clears it bit by bit with a mask write.

The handshake enables, the release delay and the pin count are captured when a sequence starts. Requests that arrive while a sequence runs do not disturb it, but their causes are still logged.

Top module: `wrs_warm_seq`

## Requirements
- R1: When any bit of `warm_cause_i` is high at a clock edge while `busy_o` is low, a sequence starts. `busy_o` is high from the next cycle until the cycle in which `sys_rst_o` drops.
- R2: Enabled handshakes run one at a time, in the fixed order `hs_en_i` bit 0 (self-refresh), 1 (configuration manager), 2 (scan manager), 3 (fabric), 4 (trace bus idle). Each request stays high until its acknowledge is sampled or it times out. No request is high while `sys_rst_o` is high.
- R3: A disabled handshake costs no cycles. With all handshakes disabled, both reset outputs are high in the cycle right after the start edge.
- R4: When an acknowledge has not come after TMO_CYC cycles, the request drops and status bit 24+i is set, where i is the handshake index. The sequence then continues.
- R5: After the last handshake, `clkmgr_rst_o` and `sys_rst_o` are both high for HOLD_CYC cycles. Then `clkmgr_rst_o` drops while `sys_rst_o` stays high.
- R6: `sys_rst_o` drops exactly d cycles after `clkmgr_rst_o`. Here d is `rel_dly_i` sampled at the start, clamped to the range 17..255.
- R7: `ext_rst_o` is high for exactly `pin_cnt_i` cycles, starting in the first cycle of reset assertion. A count of 0 keeps it low.
- R8: Status bits are sticky and set one cycle after their event:
  - `warm_cause_i[2:0]` sets bits 10:8.
  - `warm_cause_i[6:3]` sets bits 15:12.
  - `dbg_cause_i[1:0]` sets bits 19:18.
- R9: A cycle with `stat_clr_i` high clears only the status bits set in `stat_mask_i`. A set event in the same cycle wins over the clear.
- R10: A cause that arrives while `busy_o` is high does not restart the sequence, does not change its captured settings, and does not extend it. It is still logged in the status.
- R11: Status bits other than 8-10, 12-19 as listed, and 24-28 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| warm_cause_i | input | 7 | Warm-reset cause pulses: pin, fabric, software, four watchdogs |
| dbg_cause_i | input | 2 | Debug-reset cause pulses, logged only |
| hs_en_i | input | 5 | Per-handshake enable, captured at start |
| rel_dly_i | input | DLY_W | Delay between the two releases, captured at start |
| pin_cnt_i | input | PIN_W | External pin pulse length, captured at start |
| hs_req_o | output | 5 | Handshake requests, at most one high |
| hs_ack_i | input | 5 | Handshake acknowledges |
| clkmgr_rst_o | output | 1 | Clock-manager reset, freed first |
| sys_rst_o | output | 1 | Other hardware-controlled resets |
| ext_rst_o | output | 1 | External reset pin drive, active high |
| busy_o | output | 1 | Sequence in progress |
| stat_clr_i | input | 1 | Status clear strobe |
| stat_mask_i | input | 32 | Bits to clear |
| stat_o | output | 32 | Sticky status word |

## Verification
A stuck or misindexed handshake state is visible at `hs_req_o` within one cycle. It appears as a request out of order, a request that lasts longer than one cycle despite an acknowledge, or a timed-out request whose length differs from TMO_CYC. A wrong release counter shows up only at the end of the sequence, as a miscounted gap between the falls of `clkmgr_rst_o` and `sys_rst_o`. A wrong pin counter shows up as a miscounted pulse on `ext_rst_o`. Faults in the status update appear one cycle after the triggering event or clear, as wrong bits in `stat_o`.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
  localparam int unsigned NUM_HS = 5;
  localparam int unsigned HS_IW  = 3;
  localparam int unsigned STAT_W = 32;

  localparam int unsigned CAUSE_LO_LSB = 8;
  localparam int unsigned CAUSE_HI_LSB = 12;
  localparam int unsigned DBG_LSB      = 18;
  localparam int unsigned TMO_LSB      = 24;
  localparam logic [STAT_W-1:0] STAT_DEF_MASK = 32'h1F0C_F700;

  localparam int unsigned DLY_MIN = 17;
  localparam int unsigned DLY_MAX = 255;

  typedef logic [NUM_HS-1:0] hs_vec_t;

  typedef struct packed {
    logic             vld;
    logic [HS_IW-1:0] idx;
  } hs_pick_t;

  typedef enum logic [1:0] {REL_IDLE, REL_HOLD, REL_WAIT} rel_st_e;

  // lowest enabled handshake at or above 'from'
  function automatic hs_pick_t pick_hs(hs_vec_t en, logic [HS_IW-1:0] from);
    hs_pick_t p;
    p = '0;
    for (int i = NUM_HS - 1; i >= 0; i--) begin
      if (en[i] && (i >= int'(from))) begin
        p.vld = 1'b1;
        p.idx = HS_IW'(i);
      end
    end
    return p;
  endfunction

  function automatic logic [7:0] clamp_dly(logic [15:0] v);
    if (v < 16'(DLY_MIN)) return 8'(DLY_MIN);
    if (v > 16'(DLY_MAX)) return 8'(DLY_MAX);
    return v[7:0];
  endfunction
endpackage

// File: rtl/wrs_hs_engine.sv
module wrs_hs_engine
  import wrs_pkg::*;
#(
  parameter int unsigned TMO_CYC = 64
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  hs_vec_t en_i,
  input  hs_vec_t ack_i,
  output hs_vec_t req_o,
  output hs_vec_t tmo_o,
  output logic    done_o
);
  localparam int unsigned TW = $clog2(TMO_CYC + 1);

  logic             act_q;
  logic [HS_IW-1:0] cur_q;
  logic [TW-1:0]    cnt_q;
  hs_vec_t          en_q;

  hs_pick_t first, nxt;
  logic     expire, adv;

  always_comb begin
    first  = pick_hs(en_i, '0);
    nxt    = pick_hs(en_q, cur_q + HS_IW'(1));
    expire = act_q && !ack_i[cur_q] && (cnt_q == TW'(TMO_CYC - 1));
    adv    = act_q && (ack_i[cur_q] || expire);
    req_o  = act_q  ? (hs_vec_t'(1) << cur_q) : '0;
    tmo_o  = expire ? (hs_vec_t'(1) << cur_q) : '0;
    done_o = (start_i && !first.vld) || (adv && !nxt.vld);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cur_q <= '0;
      cnt_q <= '0;
      en_q  <= '0;
    end else if (start_i) begin
      en_q  <= en_i;
      cnt_q <= '0;
      act_q <= first.vld;
      cur_q <= first.idx;
    end else if (adv) begin
      cnt_q <= '0;
      act_q <= nxt.vld;
      if (nxt.vld) cur_q <= nxt.idx;
    end else if (act_q) begin
      cnt_q <= cnt_q + TW'(1);
    end
  end

  assert_req_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_o));

  assert_req_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_o && !(|(req_o & ack_i)) && !(|tmo_o) && !start_i) |=> (req_o == $past(req_o)));

  assert_tmo_on_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |tmo_o |-> (tmo_o == req_o));
endmodule

// File: rtl/wrs_rel_timer.sv
module wrs_rel_timer
  import wrs_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic [7:0] dly_i,
  output logic       clkmgr_rst_o,
  output logic       sys_rst_o,
  output logic       done_o
);
  localparam int unsigned CW = ($clog2(HOLD_CYC + 1) > 8) ? $clog2(HOLD_CYC + 1) : 8;

  rel_st_e       st_q;
  logic [CW-1:0] cnt_q;
  logic          hold_end, wait_end;

  always_comb begin
    hold_end     = (st_q == REL_HOLD) && (cnt_q == CW'(HOLD_CYC - 1));
    wait_end     = (st_q == REL_WAIT) && (cnt_q == CW'(dly_i) - CW'(1));
    clkmgr_rst_o = (st_q == REL_HOLD);
    sys_rst_o    = (st_q != REL_IDLE);
    done_o       = wait_end;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= REL_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        REL_IDLE: if (go_i) begin
          st_q  <= REL_HOLD;
          cnt_q <= '0;
        end
        REL_HOLD: if (hold_end) begin
          st_q  <= REL_WAIT;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + CW'(1);
        REL_WAIT: if (wait_end) begin
          st_q  <= REL_IDLE;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + CW'(1);
        default: st_q <= REL_IDLE;
      endcase
    end
  end

  assert_clkmgr_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clkmgr_rst_o |-> sys_rst_o);

  assert_sys_after_clk_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clkmgr_rst_o) |-> sys_rst_o);
endmodule

// File: rtl/wrs_pin_drv.sv
module wrs_pin_drv #(
  parameter int unsigned PIN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PIN_W-1:0] cnt_i,
  output logic             pin_o
);
  logic [PIN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= cnt_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - PIN_W'(1);
  end

  assign pin_o = (cnt_q != '0);

  assert_pin_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && (cnt_i == '0)) |=> !pin_o);

  assert_pin_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && (cnt_i != '0)) |=> pin_o);
endmodule

// File: rtl/wrs_status.sv
module wrs_status
  import wrs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] set_i,
  input  logic              clr_i,
  input  logic [STAT_W-1:0] mask_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~(clr_i ? mask_i : '0)) | (set_i & STAT_DEF_MASK);
  end

  assign stat_o = stat_q;

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (($past(stat_q) & ~stat_q) == '0));

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((stat_q & $past(mask_i & ~set_i)) == '0));

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(set_i) & STAT_DEF_MASK) & ~stat_q) == '0));
endmodule

// File: rtl/wrs_warm_seq.sv
module wrs_warm_seq
  import wrs_pkg::*;
#(
  parameter int unsigned TMO_CYC  = 64,
  parameter int unsigned HOLD_CYC = 4,
  parameter int unsigned DLY_W    = 9,
  parameter int unsigned PIN_W    = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [6:0]        warm_cause_i,
  input  logic [1:0]        dbg_cause_i,
  input  logic [4:0]        hs_en_i,
  input  logic [DLY_W-1:0]  rel_dly_i,
  input  logic [PIN_W-1:0]  pin_cnt_i,
  output logic [4:0]        hs_req_o,
  input  logic [4:0]        hs_ack_i,
  output logic              clkmgr_rst_o,
  output logic              sys_rst_o,
  output logic              ext_rst_o,
  output logic              busy_o,
  input  logic              stat_clr_i,
  input  logic [31:0]       stat_mask_i,
  output logic [31:0]       stat_o
);
  logic             busy_q, start, hs_done, rel_done;
  logic [7:0]       dly_q;
  logic [PIN_W-1:0] pin_q, pin_ld;
  hs_vec_t          tmo;
  logic [STAT_W-1:0] set_vec;

  assign start  = (|warm_cause_i) && !busy_q;
  assign pin_ld = start ? pin_cnt_i : pin_q;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      dly_q  <= 8'(DLY_MIN);
      pin_q  <= '0;
    end else begin
      if (start) begin
        busy_q <= 1'b1;
        dly_q  <= clamp_dly(16'(rel_dly_i));
        pin_q  <= pin_cnt_i;
      end else if (rel_done) begin
        busy_q <= 1'b0;
      end
    end
  end

  wrs_hs_engine #(.TMO_CYC(TMO_CYC)) hs_eng_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .en_i   (hs_en_i),
    .ack_i  (hs_ack_i),
    .req_o  (hs_req_o),
    .tmo_o  (tmo),
    .done_o (hs_done)
  );

  wrs_rel_timer #(.HOLD_CYC(HOLD_CYC)) rel_tmr_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (hs_done),
    .dly_i       (dly_q),
    .clkmgr_rst_o(clkmgr_rst_o),
    .sys_rst_o   (sys_rst_o),
    .done_o      (rel_done)
  );

  wrs_pin_drv #(.PIN_W(PIN_W)) pin_drv_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(hs_done),
    .cnt_i (pin_ld),
    .pin_o (ext_rst_o)
  );

  always_comb begin
    set_vec = '0;
    set_vec[CAUSE_LO_LSB +: 3] = warm_cause_i[2:0];
    set_vec[CAUSE_HI_LSB +: 4] = warm_cause_i[6:3];
    set_vec[DBG_LSB +: 2]      = dbg_cause_i;
    set_vec[TMO_LSB +: NUM_HS] = tmo;
  end

  wrs_status stat_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_vec),
    .clr_i (stat_clr_i),
    .mask_i(stat_mask_i),
    .stat_o(stat_o)
  );

  assert_no_req_in_rst_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |hs_req_o |-> !sys_rst_o);

  assert_rst_in_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> busy_o);

  assert_busy_kept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (|warm_cause_i) && !sys_rst_o) |=> busy_o);

  assert_req_needs_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |hs_req_o |-> busy_o);
endmodule

// File: tb/wrs_warm_seq_tb_top.sv
module wrs_warm_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  warm_cause_i = '0;
  logic [1:0]  dbg_cause_i = '0;
  logic [4:0]  hs_en_i = '0;
  logic [8:0]  rel_dly_i = '0;
  logic [19:0] pin_cnt_i = '0;
  logic [4:0]  hs_req_o;
  logic [4:0]  hs_ack_i = '0;
  logic        clkmgr_rst_o, sys_rst_o, ext_rst_o, busy_o;
  logic        stat_clr_i = 1'b0;
  logic [31:0] stat_mask_i = '0;
  logic [31:0] stat_o;

  localparam logic [31:0] DEF = 32'h1F0C_F700;

  always #5 clk = ~clk;

  wrs_warm_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .warm_cause_i(warm_cause_i), .dbg_cause_i(dbg_cause_i),
    .hs_en_i(hs_en_i), .rel_dly_i(rel_dly_i), .pin_cnt_i(pin_cnt_i), .hs_req_o(hs_req_o),
    .hs_ack_i(hs_ack_i), .clkmgr_rst_o(clkmgr_rst_o), .sys_rst_o(sys_rst_o),
    .ext_rst_o(ext_rst_o), .busy_o(busy_o), .stat_clr_i(stat_clr_i),
    .stat_mask_i(stat_mask_i), .stat_o(stat_o)
  );

  int checks = 0, fails = 0;
  int ord[8];
  int n_ord;
  int req_len[5];
  int hold_n, gap_n, pin_n;
  bit overlap;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic launch(logic [6:0] cause, logic [4:0] en, int dly, int pin);
    @(negedge clk);
    warm_cause_i = cause;
    hs_en_i      = en;
    rel_dly_i    = dly[8:0];
    pin_cnt_i    = pin[19:0];
    @(negedge clk);
    warm_cause_i = '0;
  endtask

  task automatic observe(logic [4:0] ack_mask);
    int prev = -1;
    n_ord = 0; hold_n = 0; gap_n = 0; pin_n = 0; overlap = 1'b0;
    for (int i = 0; i < 5; i++) req_len[i] = 0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      int cur = -1;
      for (int i = 0; i < 5; i++) if (hs_req_o[i]) cur = i;
      if (cur >= 0) begin
        req_len[cur]++;
        if (cur != prev && n_ord < 8) begin
          ord[n_ord] = cur;
          n_ord++;
        end
        if (sys_rst_o) overlap = 1'b1;
      end
      prev = cur;
      if (clkmgr_rst_o) hold_n++;
      if (sys_rst_o && !clkmgr_rst_o) gap_n++;
      if (ext_rst_o) pin_n++;
      hs_ack_i = hs_req_o & ack_mask;
      if (!busy_o && !ext_rst_o) break;
      @(negedge clk);
    end
    hs_ack_i = '0;
  endtask

  task automatic pulse_stat(logic [1:0] dbg, logic clr, logic [31:0] mask);
    @(negedge clk);
    dbg_cause_i = dbg; stat_clr_i = clr; stat_mask_i = mask;
    @(negedge clk);
    dbg_cause_i = '0; stat_clr_i = 1'b0; stat_mask_i = '0;
  endtask

  task automatic test_reset();
    chk("R1 busy after reset", 32'(busy_o), 0);
    chk("R5 clkmgr after reset", 32'(clkmgr_rst_o), 0);
    chk("R6 sys after reset", 32'(sys_rst_o), 0);
    chk("R7 pin after reset", 32'(ext_rst_o), 0);
    chk("R2 req after reset", 32'(hs_req_o), 0);
    chk("R8 stat after reset", stat_o, 0);
  endtask

  task automatic test_full();
    launch(7'b0000001, 5'h1F, 20, 5);
    chk("R1 busy at start", 32'(busy_o), 1);
    observe(5'h1F);
    chk("R2 handshake count", n_ord, 5);
    for (int i = 0; i < 5; i++) begin
      chk("R2 handshake order", ord[i], i);
      chk("R2 acked req length", req_len[i], 1);
    end
    chk("R2 no req during reset", 32'(overlap), 0);
    chk("R5 hold cycles", hold_n, 4);
    chk("R6 release gap", gap_n, 20);
    chk("R7 pin cycles", pin_n, 5);
    chk("R8 pin cause bit8", 32'(stat_o[8]), 1);
    chk("R4 no timeout bits", 32'(stat_o[28:24]), 0);
    chk("R11 undefined bits", stat_o & ~DEF, 0);
    chk("R1 busy low at end", 32'(busy_o), 0);
  endtask

  task automatic test_none();
    launch(7'b0001000, 5'h00, 3, 0);
    chk("R3 reset at once", 32'(sys_rst_o), 1);
    chk("R3 clkmgr at once", 32'(clkmgr_rst_o), 1);
    observe(5'h00);
    chk("R3 no handshakes", n_ord, 0);
    chk("R5 hold cycles", hold_n, 4);
    chk("R6 low clamp to 17", gap_n, 17);
    chk("R7 zero count no pin", pin_n, 0);
    chk("R8 watchdog cause bit12", 32'(stat_o[12]), 1);
  endtask

  task automatic test_timeout();
    launch(7'b0100000, 5'b10101, 300, 3);
    observe(5'b10001);
    chk("R3 skip count", n_ord, 3);
    chk("R3 skip order 0", ord[0], 0);
    chk("R3 skip order 2", ord[1], 2);
    chk("R3 skip order 4", ord[2], 4);
    chk("R4 timed-out req length", req_len[2], 64);
    chk("R4 later req proceeds", req_len[4], 1);
    chk("R4 scan timeout bit26", 32'(stat_o[26]), 1);
    chk("R4 other timeout bits", 32'({stat_o[28:27], stat_o[25:24]}), 0);
    chk("R6 high clamp to 255", gap_n, 255);
    chk("R7 pin cycles", pin_n, 3);
    chk("R8 watchdog cause bit14", 32'(stat_o[14]), 1);
  endtask

  task automatic test_busy_ignore();
    launch(7'b0000010, 5'b00001, 20, 0);
    repeat (10) @(negedge clk);
    warm_cause_i = 7'b0000100;
    hs_en_i      = 5'h1F;
    rel_dly_i    = 9'd40;
    pin_cnt_i    = 20'd9;
    @(negedge clk);
    warm_cause_i = '0;
    chk("R10 still busy", 32'(busy_o), 1);
    chk("R10 same request", 32'(hs_req_o), 32'h1);
    observe(5'h00);
    chk("R10 no new handshakes", n_ord, 1);
    chk("R10 old delay kept", gap_n, 20);
    chk("R10 old pin count kept", pin_n, 0);
    chk("R10 cause still logged bit10", 32'(stat_o[10]), 1);
    chk("R4 self-refresh timeout bit24", 32'(stat_o[24]), 1);
    repeat (3) @(negedge clk);
    chk("R10 no restart", 32'(busy_o), 0);
  endtask

  task automatic test_status();
    // bits now set: 8,9,10,12,14,24,26
    chk("R8 accumulated", stat_o, 32'h0500_5700);
    pulse_stat(2'b00, 1'b1, 32'h0500_0100);
    chk("R9 masked clear", stat_o, 32'h0000_5600);
    pulse_stat(2'b01, 1'b1, 32'h000C_0200);
    chk("R9 set wins over clear", stat_o, 32'h0004_5400);
    pulse_stat(2'b10, 1'b0, 32'h0);
    chk("R8 debug cause bit19", stat_o, 32'h000C_5400);
    pulse_stat(2'b00, 1'b1, 32'hFFFF_FFFF);
    chk("R9 clear all", stat_o, 0);
    launch(7'h7F, 5'h00, 17, 0);
    observe(5'h00);
    chk("R8 all warm causes", stat_o, 32'h0000_F700);
    chk("R11 undefined bits", stat_o & ~DEF, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_full();
    test_none();
    test_timeout();
    test_busy_ignore();
    test_status();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule